// File: doc/BRIEF.md
# Double-Binary Extrinsic Normalizer

This block is the output stage of a soft-in soft-out component decoder for double-binary turbo codes. For every symbol it receives four a-posteriori decision metrics, one for each of the two-bit hypotheses 00, 01, 10 and 11. It also receives the intrinsic branch-metric part that belongs to each hypothesis. It subtracts the intrinsic part from each metric to get four extrinsic values. It then finds the smallest of the four and subtracts it from the others, so that the smallest becomes zero and need not be sent. The three remaining values are scaled by a per-symbol factor in eighths and saturated to the exchange width. Together with the index of the dropped hypothesis they form the compact message passed to the other component decoder.

In parallel the block picks a hard two-bit decision: the hypothesis with the largest a-posteriori metric. This decision is used after the final iteration.

Symbols enter and leave through valid/ready handshakes. A three-stage pipeline accepts one symbol per clock when the output is not stalled.

Top module: `dbx_extrinsic_norm`

## Requirements
- R1: The extrinsic value of hypothesis j is `apos[j] - intr[j]`, computed without overflow. Both inputs are AW-bit two's complement and lane j sits at bits `[j*AW +: AW]`.
- R2: `out_min_idx` is the hypothesis with the smallest extrinsic value. On equal values the lower hypothesis code wins.
- R3: The three slots of `out_ext`, slot k at bits `[k*EW +: EW]`, carry the extrinsic values minus the minimum for the three hypotheses other than `out_min_idx`, in ascending hypothesis order.
- R4: Each slot is its normalized value times `scale/8`, where `scale` is the 3-bit input taken with the symbol, truncated toward zero. A scale of 0 gives all-zero slots.
- R5: A scaled value above `2^(EW-1)-1` is replaced by `2^(EW-1)-1`, so no slot is ever negative.
- R6: `out_hard` is the hypothesis with the largest a-posteriori metric. On equal values the lower hypothesis code wins.
- R7: Without output stalls, a symbol accepted at one clock edge appears on the outputs after the third edge, and a new symbol is accepted on every clock.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold their values. Symbols are neither lost nor duplicated, and once three symbols are stored `in_ready` drops.
- R9: Synchronous reset clears `out_valid` and empties the pipeline. With nothing held on the output, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block can take the input symbol |
| apos | input | 4*AW | A-posteriori metrics, lane j for hypothesis j |
| intr | input | 4*AW | Intrinsic branch-metric parts, lane j for hypothesis j |
| scale | input | 3 | Scaling factor in eighths for this symbol |
| out_valid | output | 1 | Output message present |
| out_ready | input | 1 | Downstream takes the message |
| out_min_idx | output | 2 | Hypothesis whose normalized value is zero |
| out_ext | output | 3*EW | Three scaled normalized extrinsic values |
| out_hard | output | 2 | Hard two-bit decision |

## Verification
The hardest cases to reach are the extreme arithmetic ones. These are a normalized difference near `2^(AW+1)` that must saturate, and exact ties in both the minimum search and the maximum search. Random metrics almost never produce them, so a vector table places the metrics at the ends of the input range and repeats values on purpose. A second hard case is a full pipeline behind a stalled output. The bench reaches it by holding `out_ready` low while it pushes symbols until `in_ready` drops. It then also takes a reset there and checks that the pipeline is empty afterwards.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  localparam int NHYP      = 4;
  localparam int HIDX_W    = 2;
  localparam int NSENT     = NHYP - 1;
  localparam int SCL_W     = 3;
  localparam int SCL_SHIFT = 3;
endpackage

// File: rtl/dbx_ext_stage.sv
// Forms the four extrinsic values and picks the hard decision.
module dbx_ext_stage
  import dbx_pkg::*;
#(
  parameter int AW = 10,
  localparam int XW = AW + 1
) (
  input  logic [NHYP*AW-1:0] apos_i,
  input  logic [NHYP*AW-1:0] intr_i,
  output logic [NHYP*XW-1:0] ext_o,
  output logic [HIDX_W-1:0]  hard_o
);
  logic signed [AW-1:0] a_s [NHYP];
  logic signed [AW-1:0] b_s [NHYP];
  logic signed [XW-1:0] e_s [NHYP];

  always_comb begin
    for (int j = 0; j < NHYP; j++) begin
      a_s[j] = apos_i[j*AW +: AW];
      b_s[j] = intr_i[j*AW +: AW];
      e_s[j] = XW'(a_s[j]) - XW'(b_s[j]);
      ext_o[j*XW +: XW] = e_s[j];
    end
  end

  // Largest a-posteriori metric; strict compare keeps the lower code on a tie.
  logic signed [AW-1:0] best;
  always_comb begin
    best   = a_s[0];
    hard_o = '0;
    for (int j = 1; j < NHYP; j++) begin
      if (a_s[j] > best) begin
        best   = a_s[j];
        hard_o = HIDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/dbx_min_norm.sv
// Finds the minimum extrinsic value, subtracts it, and packs the three others.
module dbx_min_norm
  import dbx_pkg::*;
#(
  parameter int XW = 11
) (
  input  logic [NHYP*XW-1:0]  ext_i,
  output logic [HIDX_W-1:0]   min_o,
  output logic [NSENT*XW-1:0] sel_o
);
  logic signed [XW-1:0] e_s [NHYP];
  logic signed [XW-1:0] lo;
  logic signed [XW:0]   diff [NHYP];
  logic [XW-1:0]        norm [NHYP];

  always_comb begin
    for (int j = 0; j < NHYP; j++) e_s[j] = ext_i[j*XW +: XW];
    lo    = e_s[0];
    min_o = '0;
    for (int j = 1; j < NHYP; j++) begin
      if (e_s[j] < lo) begin
        lo    = e_s[j];
        min_o = HIDX_W'(j);
      end
    end
    for (int j = 0; j < NHYP; j++) begin
      diff[j] = (XW+1)'(e_s[j]) - (XW+1)'(lo);
      norm[j] = diff[j][XW-1:0];
    end
  end

  // Slot k carries hypothesis k below the minimum index, k+1 from it on.
  always_comb begin
    for (int k = 0; k < NSENT; k++) begin
      if (HIDX_W'(k) < min_o) sel_o[k*XW +: XW] = norm[k];
      else                    sel_o[k*XW +: XW] = norm[k+1];
    end
  end
endmodule

// File: rtl/dbx_scale_sat.sv
// Multiplies one non-negative value by scale/8, truncates, saturates.
module dbx_scale_sat
  import dbx_pkg::*;
#(
  parameter int XW = 11,
  parameter int EW = 8
) (
  input  logic [XW-1:0]    val_i,
  input  logic [SCL_W-1:0] scale_i,
  output logic [EW-1:0]    val_o
);
  localparam int PW = XW + SCL_W;
  localparam logic [XW-1:0] MAXV = XW'((1 << (EW-1)) - 1);

  logic [PW-1:0] prod;
  logic [XW-1:0] quot;

  always_comb begin
    prod  = PW'(val_i) * PW'(scale_i);
    quot  = prod[PW-1:SCL_SHIFT];
    val_o = (quot > MAXV) ? MAXV[EW-1:0] : quot[EW-1:0];
  end
endmodule

// File: rtl/dbx_extrinsic_norm.sv
module dbx_extrinsic_norm
  import dbx_pkg::*;
#(
  parameter int AW = 10,
  parameter int EW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [4*AW-1:0]     apos,
  input  logic [4*AW-1:0]     intr,
  input  logic [2:0]          scale,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_min_idx,
  output logic [3*EW-1:0]     out_ext,
  output logic [1:0]          out_hard
);
  localparam int XW = AW + 1;

  // Stage occupancy and ready chain.
  logic v1, v2, v3;
  logic rdy1, rdy2, rdy3;
  assign rdy3     = !v3 || out_ready;
  assign rdy2     = !v2 || rdy3;
  assign rdy1     = !v1 || rdy2;
  assign in_ready = rdy1;

  // Stage 1: extrinsic values and hard decision.
  logic [NHYP*XW-1:0] ext_c, ext1;
  logic [HIDX_W-1:0]  hard_c, hard1;
  logic [SCL_W-1:0]   scl1;

  dbx_ext_stage #(.AW(AW)) ext_i (
    .apos_i (apos),
    .intr_i (intr),
    .ext_o  (ext_c),
    .hard_o (hard_c)
  );

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else if (rdy1) v1 <= in_valid;
    if (rdy1 && in_valid) begin
      ext1  <= ext_c;
      hard1 <= hard_c;
      scl1  <= scale;
    end
  end

  // Stage 2: minimum search, normalization and slot selection.
  logic [HIDX_W-1:0]   min_c, min2, hard2;
  logic [NSENT*XW-1:0] sel_c, sel2;
  logic [SCL_W-1:0]    scl2;

  dbx_min_norm #(.XW(XW)) min_i (
    .ext_i (ext1),
    .min_o (min_c),
    .sel_o (sel_c)
  );

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else if (rdy2) v2 <= v1;
    if (rdy2 && v1) begin
      min2  <= min_c;
      sel2  <= sel_c;
      hard2 <= hard1;
      scl2  <= scl1;
    end
  end

  // Stage 3: scaling and saturation into the output registers.
  logic [NSENT*EW-1:0] scl_c;

  for (genvar k = 0; k < NSENT; k++) begin : g_slot
    dbx_scale_sat #(.XW(XW), .EW(EW)) sat_i (
      .val_i   (sel2[k*XW +: XW]),
      .scale_i (scl2),
      .val_o   (scl_c[k*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else if (rdy3) v3 <= v2;
    if (rdy3 && v2) begin
      out_ext     <= scl_c;
      out_min_idx <= min2;
      out_hard    <= hard2;
    end
  end

  assign out_valid = v3;
endmodule

// File: rtl/dbx_extrinsic_norm_chk.sv
module dbx_extrinsic_norm_chk #(
  parameter int EW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [1:0]      out_min_idx,
  input logic [3*EW-1:0] out_ext,
  input logic [1:0]      out_hard
);
  // R9: reset empties the output stage.
  a_r9_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: with nothing held on the output, input is accepted.
  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R8: a stalled message holds still.
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ext)
      && $stable(out_min_idx) && $stable(out_hard)));

  // R5: saturation keeps every slot non-negative.
  for (genvar k = 0; k < 3; k++) begin : g_sign
    a_r5_slot_nonneg: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !out_ext[k*EW + EW - 1]);
  end
endmodule

bind dbx_extrinsic_norm dbx_extrinsic_norm_chk #(.EW(EW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_min_idx (out_min_idx),
  .out_ext     (out_ext),
  .out_hard    (out_hard)
);

// File: tb/dbx_extrinsic_norm_tb.sv
module dbx_extrinsic_norm_tb_top;
  localparam int AW = 10;
  localparam int EW = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*AW-1:0] apos = '0;
  logic [4*AW-1:0] intr = '0;
  logic [2:0] scale = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_min_idx;
  logic [3*EW-1:0] out_ext;
  logic [1:0] out_hard;

  always #2 clk = ~clk;

  dbx_extrinsic_norm #(.AW(AW), .EW(EW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .apos(apos), .intr(intr), .scale(scale), .out_valid(out_valid),
    .out_ready(out_ready), .out_min_idx(out_min_idx), .out_ext(out_ext),
    .out_hard(out_hard)
  );

  typedef struct packed {
    logic [1:0]      mn;
    logic [1:0]      hd;
    logic [3*EW-1:0] ext;
  } res_t;

  // Stimulus vectors with hand-derived minimum index and hard decision.
  localparam int TA [NV][4] = '{'{0,0,0,0}, '{100,50,20,80}, '{-5,-5,30,30},
    '{511,-512,0,0}, '{3,20,40,1}, '{200,-300,7,7},
    '{-512,-512,-512,-512}, '{10,11,12,13}};
  localparam int TI [NV][4] = '{'{0,0,0,0}, '{10,10,10,10}, '{0,0,0,0},
    '{-512,511,0,0}, '{0,0,0,0}, '{300,-300,8,0},
    '{511,511,511,-512}, '{13,12,11,10}};
  localparam int TS    [NV] = '{7, 4, 7, 7, 1, 0, 7, 6};
  localparam int TMIN  [NV] = '{0, 2, 0, 1, 3, 0, 0, 0};
  localparam int THARD [NV] = '{0, 0, 2, 0, 2, 0, 0, 3};

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int stall_mode = 0;
  bit done = 0;

  res_t exp_q [$];
  int   cyc_q [$];
  bit   lat_q [$];
  bit   have_snap = 0;
  res_t snap;

  function automatic res_t model(input int a[4], input int b[4], input int s);
    int e[4];
    int mi, hi, k;
    res_t r;
    for (int j = 0; j < 4; j++) e[j] = a[j] - b[j];
    mi = 0; hi = 0;
    for (int j = 1; j < 4; j++) begin
      if (e[j] < e[mi]) mi = j;
      if (a[j] > a[hi]) hi = j;
    end
    r.mn = 2'(mi);
    r.hd = 2'(hi);
    k = 0;
    for (int j = 0; j < 4; j++) begin
      if (j != mi) begin
        int v;
        v = ((e[j] - e[mi]) * s) / 8;
        if (v > (1 << (EW-1)) - 1) v = (1 << (EW-1)) - 1;
        r.ext[k*EW +: EW] = EW'(v);
        k++;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic tick(input logic v, input int a[4], input int b[4], input int s,
                      input bit use_tab, input int tmin, input int thard, output bit acc);
    @(negedge clk);
    cyc++;
    out_ready = (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    in_valid = v;
    for (int j = 0; j < 4; j++) begin
      logic [31:0] ta, tb;
      ta = a[j]; tb = b[j];
      apos[j*AW +: AW] = ta[AW-1:0];
      intr[j*AW +: AW] = tb[AW-1:0];
    end
    scale = 3'(s);
    #1;
    if (have_snap) begin
      check(out_valid && out_ext == snap.ext && out_min_idx == snap.mn && out_hard == snap.hd,
            "R8 outputs held under stall", {out_min_idx, out_hard, out_ext}, {snap.mn, snap.hd, snap.ext});
      have_snap = 0;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 message with no symbol pending", 32'(out_ext), 0);
      end else begin
        res_t ex;
        int c;
        bit l;
        ex = exp_q.pop_front(); c = cyc_q.pop_front(); l = lat_q.pop_front();
        check(out_min_idx == ex.mn, "R2 minimum index", 32'(out_min_idx), 32'(ex.mn));
        check(out_hard == ex.hd, "R6 hard decision", 32'(out_hard), 32'(ex.hd));
        check(out_ext == ex.ext, "R1/R3/R4/R5 extrinsic slots", 32'(out_ext), 32'(ex.ext));
        if (l) check(cyc - c == 3, "R7 latency", 32'(cyc - c), 3);
      end
    end else if (out_valid) begin
      have_snap = 1;
      snap.mn = out_min_idx; snap.hd = out_hard; snap.ext = out_ext;
    end
    acc = v && in_ready;
    if (acc) begin
      res_t r;
      r = model(a, b, s);
      if (use_tab) begin
        r.mn = 2'(tmin);
        r.hd = 2'(thard);
      end
      exp_q.push_back(r);
      cyc_q.push_back(cyc);
      lat_q.push_back(stall_mode == 0);
    end
  endtask

  task automatic drain();
    int z[4] = '{0,0,0,0};
    bit acc;
    for (int n = 0; n < 60 && exp_q.size() != 0; n++) tick(1'b0, z, z, 0, 0, 0, 0, acc);
    check(exp_q.size() == 0, "R8 all symbols delivered", 32'(exp_q.size()), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int z[4] = '{0,0,0,0};
    bit acc;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 out_valid low in reset", 32'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R9 in_ready high after reset", 32'(in_ready), 1);

    // Vector table, back to back, no stalls: one accepted per clock.
    stall_mode = 0;
    for (int i = 0; i < NV; i++) begin
      tick(1'b1, TA[i], TI[i], TS[i], 1, TMIN[i], THARD[i], acc);
      check(acc, "R7 symbol accepted every clock", 32'(acc), 1);
    end
    drain();

    // Randomized metrics with a throttled output.
    stall_mode = 1;
    for (int i = 0; i < 300; i++) begin
      int a[4];
      int b[4];
      int s;
      for (int j = 0; j < 4; j++) begin
        a[j] = int'($urandom_range(0, 1023)) - 512;
        b[j] = int'($urandom_range(0, 1023)) - 512;
      end
      s = int'($urandom_range(0, 7));
      acc = 0;
      for (int t = 0; t < 20 && !acc; t++) tick(1'b1, a, b, s, 0, 0, 0, acc);
    end
    drain();

    // Full pipeline behind a blocked output, then reset.
    stall_mode = 2;
    for (int i = 0; i < 3; i++) tick(1'b1, TA[1], TI[1], 4, 0, 0, 0, acc);
    tick(1'b1, TA[2], TI[2], 7, 0, 0, 0, acc);
    check(!acc, "R8 in_ready low when three symbols held", 32'(acc), 0);
    check(out_valid == 1'b1, "R8 held message still valid", 32'(out_valid), 1);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 reset empties pipeline", 32'(out_valid), 0);
    rst = 1'b0;
    exp_q.delete(); cyc_q.delete(); lat_q.delete();
    have_snap = 0;
    stall_mode = 0;
    for (int i = 0; i < 5; i++) tick(1'b0, z, z, 0, 0, 0, 0, acc);
    check(out_valid == 1'b0, "R9 no stale message after reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after mid-run reset", 32'(in_ready), 1);

    // Table again after reset to confirm clean restart.
    for (int i = 0; i < NV; i++) tick(1'b1, TA[i], TI[i], TS[i], 1, TMIN[i], THARD[i], acc);
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule